// File: doc/BRIEF.md
# UART FIFO Threshold Control Unit

This block decides, for one UART channel with 64-entry transmit and receive queues, when the queues have crossed their programmed levels. It watches the receive fill count and the transmit free-space count. It raises a receive-level interrupt, a transmit-level interrupt and a flow-control halt request. The halt request can drive a request-to-send line, or it can tell a separate sender to emit XOFF and XON characters. The queues, the serial shifters and the character sender sit outside this block.

Two 8-bit registers set the levels, and every 4-bit field counts in steps of four entries. The hysteresis register holds a halt level and a resume level. The trigger register holds one interrupt level for each direction. A trigger field of zero falls back to a coarse 2-bit selection that comes in as an input, and each direction falls back on its own. If the whole hysteresis register is zero, the coarse receive level becomes the halt level and the resume level sits four entries below it. A write lands only while two configuration qualifiers are both high. The block accepts any programmed value, including a resume level at or above the halt level.

Top module: `uft_top`

## Requirements
- R1: While reset is held, and on the first cycles after it, both registers read as 0 and `rx_irq`, `tx_irq` and `flow_halt` are 0.
- R2: A write with `reg_we`=1 changes a register only when `cfg_feat_en` and `cfg_bank_sel` are both 1. Otherwise both registers keep their values, which shows in the read data.
- R3: `reg_rdata` is combinational. Address 0 returns the hysteresis register, address 1 returns the trigger register, and addresses 2 and 3 return 0.
- R4: The active receive level is 4 × trigger bits [7:4] when that field is non-zero. When it is zero, the level follows `rx_coarse_sel`: 0 gives 8, 1 gives 16, 2 gives 56 and 3 gives 60.
- R5: The active transmit level is 4 × trigger bits [3:0] when that field is non-zero. When it is zero, the level follows `tx_coarse_sel`: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 56.
- R6: `rx_irq` is 1 in the cycle after a clock edge at which `rx_fill` is at or above the active receive level, and 0 otherwise.
- R7: `tx_irq` is 1 in the cycle after a clock edge at which `tx_free` is at or above the active transmit level, and 0 otherwise.
- R8: With a non-zero hysteresis register, the halt level is 4 × bits [3:0] and the resume level is 4 × bits [7:4]. `flow_halt` sets one edge after `rx_fill` is at or above the halt level. It clears one edge after `rx_fill` is at or below the resume level. Between those two points it holds.
- R9: With the hysteresis register at 0, the halt level is the coarse receive level from R4, and the resume level is that level minus 4.
- R10: A resume level at or above the halt level is accepted. Each edge applies the R8 rule to the current state, so the output alternates for as long as the fill count meets both conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_feat_en | input | 1 | Write qualifier: enhanced features enabled |
| cfg_bank_sel | input | 1 | Write qualifier: control-register bank selected |
| rx_coarse_sel | input | 2 | Coarse receive level selection |
| tx_coarse_sel | input | 2 | Coarse transmit level selection |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| rx_fill | input | 7 | Receive queue fill count (0 to 64) |
| tx_free | input | 7 | Transmit queue free-space count (0 to 64) |
| rx_irq | output | 1 | Receive level reached |
| tx_irq | output | 1 | Transmit space level reached |
| flow_halt | output | 1 | Request to halt the remote transmitter |

## Verification
The three outputs have one register each, so their values are due one clock edge after the counts, selections and register contents that the edge sampled. A register write changes the levels on the same edge that still evaluates the outputs against the old levels, so a new level shows one edge later. Read data is combinational and reflects a write immediately after its edge. The bench drives inputs on the falling edge and updates its model on the rising edge using the pre-write register values. It compares every output on the following falling edge.

// File: rtl/uft_pkg.sv
package uft_pkg;

  localparam int FIELD_W = 4;
  localparam int REG_W   = 8;
  localparam int LVL_W   = 8;
  localparam int A_HYST  = 0;
  localparam int A_TRIG  = 1;
  localparam int NREG    = 2;

  typedef enum logic {FC_RUN = 1'b0, FC_HALT = 1'b1} fc_state_e;

  // Field value to entry count: steps of four.
  function automatic logic [LVL_W-1:0] scale_field(input logic [FIELD_W-1:0] f);
    return {2'b00, f, 2'b00};
  endfunction

  function automatic logic [LVL_W-1:0] rx_coarse_lvl(input logic [1:0] s);
    logic [LVL_W-1:0] v;
    case (s)
      2'd0:    v = 8'd8;
      2'd1:    v = 8'd16;
      2'd2:    v = 8'd56;
      default: v = 8'd60;
    endcase
    return v;
  endfunction

  function automatic logic [LVL_W-1:0] tx_coarse_lvl(input logic [1:0] s);
    logic [LVL_W-1:0] v;
    case (s)
      2'd0:    v = 8'd8;
      2'd1:    v = 8'd16;
      2'd2:    v = 8'd32;
      default: v = 8'd56;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/uft_regs.sv
module uft_regs
  import uft_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_allow,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [REG_W-1:0]           wdata,
  output logic [NREG-1:0][REG_W-1:0] regs_q,
  output logic [REG_W-1:0]           rdata
);

  logic [NREG-1:0] ld_en;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [REG_W-1:0] d;

    always_comb begin
      ld_en[g] = we & wr_allow & (addr == ADDR_W'(g));
      d        = ld_en[g] ? wdata : regs_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (ld_en[g]) begin
        regs_q[g] <= d;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr == ADDR_W'(i)) rdata = regs_q[i];
    end
  end

endmodule

// File: rtl/uft_trig_dir.sv
module uft_trig_dir
  import uft_pkg::*;
#(
  parameter int FILL_W = 7,
  parameter bit IS_RX  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] field,
  input  logic [1:0]         coarse_sel,
  input  logic [FILL_W-1:0]  count,
  output logic [FILL_W-1:0]  thr,
  output logic               irq
);

  logic [LVL_W-1:0] coarse_lvl;
  logic             irq_d;

  if (IS_RX) begin : g_rx
    always_comb coarse_lvl = rx_coarse_lvl(coarse_sel);
  end else begin : g_tx
    always_comb coarse_lvl = tx_coarse_lvl(coarse_sel);
  end

  always_comb begin
    thr   = (field != '0) ? FILL_W'(scale_field(field)) : FILL_W'(coarse_lvl);
    irq_d = (count >= thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      irq <= irq_d;
    end
  end

endmodule

// File: rtl/uft_hyst.sv
module uft_hyst
  import uft_pkg::*;
#(
  parameter int FILL_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  hyst_reg,
  input  logic [1:0]        rx_coarse_sel,
  input  logic [FILL_W-1:0] rx_fill,
  output logic [FILL_W-1:0] halt_lvl,
  output logic [FILL_W-1:0] res_lvl,
  output logic              halt
);

  localparam logic [LVL_W-1:0] STEP = 8'd4;

  fc_state_e        st_q, st_d;
  logic [LVL_W-1:0] coarse;
  logic             use_coarse;

  always_comb begin
    coarse     = rx_coarse_lvl(rx_coarse_sel);
    use_coarse = (hyst_reg == '0);
    if (use_coarse) begin
      halt_lvl = FILL_W'(coarse);
      res_lvl  = FILL_W'(coarse - STEP);
    end else begin
      halt_lvl = FILL_W'(scale_field(hyst_reg[FIELD_W-1:0]));
      res_lvl  = FILL_W'(scale_field(hyst_reg[REG_W-1:FIELD_W]));
    end
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      FC_RUN:  if (rx_fill >= halt_lvl) st_d = FC_HALT;
      FC_HALT: if (rx_fill <= res_lvl)  st_d = FC_RUN;
      default: st_d = FC_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= FC_RUN;
    end else begin
      st_q <= st_d;
    end
  end

  assign halt = (st_q == FC_HALT);

endmodule

// File: rtl/uft_top.sv
module uft_top
  import uft_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 2,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_feat_en,
  input  logic              cfg_bank_sel,
  input  logic [1:0]        rx_coarse_sel,
  input  logic [1:0]        tx_coarse_sel,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [FILL_W-1:0] rx_fill,
  input  logic [FILL_W-1:0] tx_free,
  output logic              rx_irq,
  output logic              tx_irq,
  output logic              flow_halt
);

  // Reset: asynchronous assert, two-stage synchronous release.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NREG-1:0][REG_W-1:0] regs_q;
  logic [REG_W-1:0]           hyst_q;
  logic [REG_W-1:0]           trig_q;
  logic                       wr_allow;

  assign wr_allow = cfg_feat_en & cfg_bank_sel;

  uft_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_allow (wr_allow),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .regs_q   (regs_q),
    .rdata    (reg_rdata)
  );

  assign hyst_q = regs_q[A_HYST];
  assign trig_q = regs_q[A_TRIG];

  // Per-direction trigger: index 0 receive, index 1 transmit.
  logic [1:0][FIELD_W-1:0] dir_field;
  logic [1:0][1:0]         dir_sel;
  logic [1:0][FILL_W-1:0]  dir_cnt;
  logic [1:0][FILL_W-1:0]  dir_thr;
  logic [1:0]              dir_irq;

  assign dir_field[0] = trig_q[REG_W-1:FIELD_W];
  assign dir_field[1] = trig_q[FIELD_W-1:0];
  assign dir_sel[0]   = rx_coarse_sel;
  assign dir_sel[1]   = tx_coarse_sel;
  assign dir_cnt[0]   = rx_fill;
  assign dir_cnt[1]   = tx_free;

  for (genvar g = 0; g < 2; g++) begin : g_dir
    uft_trig_dir #(.FILL_W(FILL_W), .IS_RX(g == 0)) u_dir (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .field      (dir_field[g]),
      .coarse_sel (dir_sel[g]),
      .count      (dir_cnt[g]),
      .thr        (dir_thr[g]),
      .irq        (dir_irq[g])
    );
  end

  logic [FILL_W-1:0] rx_thr;
  logic [FILL_W-1:0] tx_thr;
  assign rx_thr = dir_thr[0];
  assign tx_thr = dir_thr[1];
  assign rx_irq = dir_irq[0];
  assign tx_irq = dir_irq[1];

  logic [FILL_W-1:0] halt_lvl;
  logic [FILL_W-1:0] res_lvl;

  uft_hyst #(.FILL_W(FILL_W)) u_hyst (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .hyst_reg      (hyst_q),
    .rx_coarse_sel (rx_coarse_sel),
    .rx_fill       (rx_fill),
    .halt_lvl      (halt_lvl),
    .res_lvl       (res_lvl),
    .halt          (flow_halt)
  );

endmodule

// File: rtl/uft_chk.sv
module uft_chk #(
  parameter int FILL_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_feat_en,
  input logic              cfg_bank_sel,
  input logic              reg_we,
  input logic [7:0]        hyst_q,
  input logic [7:0]        trig_q,
  input logic [FILL_W-1:0] rx_fill,
  input logic [FILL_W-1:0] tx_free,
  input logic [FILL_W-1:0] rx_thr,
  input logic [FILL_W-1:0] tx_thr,
  input logic [FILL_W-1:0] halt_lvl,
  input logic [FILL_W-1:0] res_lvl,
  input logic              rx_irq,
  input logic              tx_irq,
  input logic              flow_halt
);

  assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !(cfg_feat_en && cfg_bank_sel)) |=>
      (hyst_q == $past(hyst_q) && trig_q == $past(trig_q)));

  assert_rx_lvl_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_thr >= FILL_W'(4)) && (rx_thr <= FILL_W'(60)) && (rx_thr[1:0] == 2'b00));

  assert_tx_lvl_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_thr >= FILL_W'(4)) && (tx_thr <= FILL_W'(60)) && (tx_thr[1:0] == 2'b00));

  assert_rx_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fill >= rx_thr) |=> rx_irq);

  assert_rx_irq_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fill < rx_thr) |=> !rx_irq);

  assert_tx_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_free >= tx_thr) |=> tx_irq);

  assert_tx_irq_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_free < tx_thr) |=> !tx_irq);

  assert_halt_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_halt && rx_fill >= halt_lvl) |=> flow_halt);

  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_halt && rx_fill > res_lvl) |=> flow_halt);

  assert_run_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_halt && rx_fill < halt_lvl) |=> !flow_halt);

  assert_fallback_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hyst_q == 8'h00) |-> (halt_lvl == res_lvl + FILL_W'(4)));

endmodule

bind uft_top uft_chk #(.FILL_W(FILL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .cfg_feat_en  (cfg_feat_en),
  .cfg_bank_sel (cfg_bank_sel),
  .reg_we       (reg_we),
  .hyst_q       (hyst_q),
  .trig_q       (trig_q),
  .rx_fill      (rx_fill),
  .tx_free      (tx_free),
  .rx_thr       (rx_thr),
  .tx_thr       (tx_thr),
  .halt_lvl     (halt_lvl),
  .res_lvl      (res_lvl),
  .rx_irq       (rx_irq),
  .tx_irq       (tx_irq),
  .flow_halt    (flow_halt)
);

// File: tb/uft_top_tb.sv
module uft_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 200000;

  logic       clk;
  logic       rst_n;
  logic       cfg_feat_en, cfg_bank_sel;
  logic [1:0] rx_coarse_sel, tx_coarse_sel;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [6:0] rx_fill, tx_free;
  logic       rx_irq, tx_irq, flow_halt;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [7:0] m_hyst, m_trig;
  logic       m_rx, m_tx, m_halt;

  uft_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_feat_en(cfg_feat_en), .cfg_bank_sel(cfg_bank_sel),
    .rx_coarse_sel(rx_coarse_sel), .tx_coarse_sel(tx_coarse_sel),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_fill(rx_fill), .tx_free(tx_free),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .flow_halt(flow_halt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected-value functions built from the requirements.
  function automatic int e_rx_coarse(input logic [1:0] s);
    case (s) 2'd0: return 8; 2'd1: return 16; 2'd2: return 56; default: return 60; endcase
  endfunction
  function automatic int e_tx_coarse(input logic [1:0] s);
    case (s) 2'd0: return 8; 2'd1: return 16; 2'd2: return 32; default: return 56; endcase
  endfunction
  function automatic int e_rx_thr(input logic [7:0] t, input logic [1:0] s);
    return (t[7:4] != 0) ? 4 * int'(t[7:4]) : e_rx_coarse(s);
  endfunction
  function automatic int e_tx_thr(input logic [7:0] t, input logic [1:0] s);
    return (t[3:0] != 0) ? 4 * int'(t[3:0]) : e_tx_coarse(s);
  endfunction
  function automatic int e_halt_lvl(input logic [7:0] h, input logic [1:0] s);
    return (h == 0) ? e_rx_coarse(s) : 4 * int'(h[3:0]);
  endfunction
  function automatic int e_res_lvl(input logic [7:0] h, input logic [1:0] s);
    return (h == 0) ? e_rx_coarse(s) - 4 : 4 * int'(h[7:4]);
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One clock: model update at the rising edge, compare at the falling edge.
  task automatic step(input string tag);
    logic n_rx, n_tx, n_h;
    int   exp_rd;
    @(posedge clk);
    n_rx = int'(rx_fill) >= e_rx_thr(m_trig, rx_coarse_sel);
    n_tx = int'(tx_free) >= e_tx_thr(m_trig, tx_coarse_sel);
    if (m_halt) n_h = !(int'(rx_fill) <= e_res_lvl(m_hyst, rx_coarse_sel));
    else        n_h = int'(rx_fill) >= e_halt_lvl(m_hyst, rx_coarse_sel);
    if (reg_we && cfg_feat_en && cfg_bank_sel) begin
      if (reg_addr == 2'd0) m_hyst = reg_wdata;
      if (reg_addr == 2'd1) m_trig = reg_wdata;
    end
    m_rx = n_rx; m_tx = n_tx; m_halt = n_h;
    @(negedge clk);
    reg_we = 1'b0;
    exp_rd = (reg_addr == 2'd0) ? int'(m_hyst) : (reg_addr == 2'd1) ? int'(m_trig) : 0;
    check(tag, "rx_irq", int'(rx_irq), int'(m_rx));
    check(tag, "tx_irq", int'(tx_irq), int'(m_tx));
    check(tag, "flow_halt", int'(flow_halt), int'(m_halt));
    check(tag, "reg_rdata", int'(reg_rdata), exp_rd);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic fe, input logic bs, input string tag);
    cfg_feat_en = fe; cfg_bank_sel = bs;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step(tag);
    cfg_feat_en = 1'b1; cfg_bank_sel = 1'b1;
  endtask

  task automatic drive(input int rf, input int tf, input logic [1:0] rs, input logic [1:0] ts, input string tag);
    rx_fill = 7'(rf); tx_free = 7'(tf); rx_coarse_sel = rs; tx_coarse_sel = ts;
    step(tag);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    rst_n = 1'b0; cfg_feat_en = 1'b0; cfg_bank_sel = 1'b0;
    rx_coarse_sel = 2'd0; tx_coarse_sel = 2'd0; reg_we = 1'b0;
    reg_addr = 2'd0; reg_wdata = 8'h00; rx_fill = 7'd0; tx_free = 7'd0;
    m_hyst = 8'h00; m_trig = 8'h00; m_rx = 1'b0; m_tx = 1'b0; m_halt = 1'b0;

    // R1: reset state.
    repeat (3) @(negedge clk);
    check("R1", "rx_irq", int'(rx_irq), 0);
    check("R1", "tx_irq", int'(tx_irq), 0);
    check("R1", "flow_halt", int'(flow_halt), 0);
    check("R1", "hyst read", int'(reg_rdata), 0);
    reg_addr = 2'd1;
    #1 check("R1", "trig read", int'(reg_rdata), 0);
    rst_n = 1'b1;
    repeat (4) step("R1");
    cfg_feat_en = 1'b1; cfg_bank_sel = 1'b1;

    // R2: gated writes.
    wr(2'd0, 8'h5A, 1'b0, 1'b1, "R2");
    wr(2'd1, 8'hA5, 1'b1, 1'b0, "R2");
    wr(2'd1, 8'h33, 1'b0, 1'b0, "R2");
    reg_addr = 2'd1; step("R2");
    wr(2'd0, 8'h5A, 1'b1, 1'b1, "R2");

    // R3: read map.
    reg_addr = 2'd2; step("R3");
    reg_addr = 2'd3; step("R3");
    reg_addr = 2'd0; step("R3");
    wr(2'd0, 8'h00, 1'b1, 1'b1, "R3");

    // R4 / R5: coarse fallbacks and fine overrides.
    for (int s = 0; s < 4; s++) begin
      drive(e_rx_coarse(2'(s)) - 1, e_tx_coarse(2'(s)) - 1, 2'(s), 2'(s), "R4");
      drive(e_rx_coarse(2'(s)), e_tx_coarse(2'(s)) - 1, 2'(s), 2'(s), "R4");
      drive(0, e_tx_coarse(2'(s)), 2'(s), 2'(s), "R5");
      drive(0, 0, 2'(s), 2'(s), "R5");
    end
    wr(2'd1, 8'h30, 1'b1, 1'b1, "R4");
    drive(11, 55, 2'd3, 2'd3, "R4");
    drive(12, 55, 2'd3, 2'd3, "R4");
    wr(2'd1, 8'h32, 1'b1, 1'b1, "R5");
    drive(0, 7, 2'd3, 2'd3, "R5");
    drive(0, 8, 2'd3, 2'd3, "R5");
    drive(64, 64, 2'd3, 2'd3, "R6");
    drive(0, 0, 2'd3, 2'd3, "R7");

    // R9: hysteresis register zero, coarse receive level 16.
    wr(2'd0, 8'h00, 1'b1, 1'b1, "R9");
    drive(16, 0, 2'd1, 2'd0, "R9");
    drive(13, 0, 2'd1, 2'd0, "R9");
    drive(12, 0, 2'd1, 2'd0, "R9");
    drive(15, 0, 2'd1, 2'd0, "R9");

    // R8: halt 40, resume 12.
    wr(2'd0, 8'h3A, 1'b1, 1'b1, "R8");
    drive(39, 0, 2'd0, 2'd0, "R8");
    drive(40, 0, 2'd0, 2'd0, "R8");
    drive(20, 0, 2'd0, 2'd0, "R8");
    drive(13, 0, 2'd0, 2'd0, "R8");
    drive(12, 0, 2'd0, 2'd0, "R8");
    drive(30, 0, 2'd0, 2'd0, "R8");

    // R10: resume 20 above halt 8.
    wr(2'd0, 8'h52, 1'b1, 1'b1, "R10");
    for (int k = 0; k < 4; k++) drive(10, 0, 2'd0, 2'd0, "R10");
    drive(30, 0, 2'd0, 2'd0, "R10");
    drive(30, 0, 2'd0, 2'd0, "R10");

    // Random mix.
    for (int k = 0; k < 3000; k++) begin
      rx_fill = 7'($urandom_range(0, 64));
      tx_free = 7'($urandom_range(0, 64));
      rx_coarse_sel = 2'($urandom_range(0, 3));
      tx_coarse_sel = 2'($urandom_range(0, 3));
      reg_addr = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 7) == 0) begin
        reg_we = 1'b1;
        reg_wdata = 8'($urandom);
        cfg_feat_en = ($urandom_range(0, 3) != 0);
        cfg_bank_sel = ($urandom_range(0, 3) != 0);
      end
      step("R2/R3/R6/R7/R8");
      cfg_feat_en = 1'b1; cfg_bank_sel = 1'b1;
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule